// File: doc/BRIEF.md
# Shared-Function I/O Pin Controller

This block decides who controls one general-purpose I/O pin at any moment. The pin can serve four users: plain port logic, a serial data line in three-wire or two-wire mode, an inverted PWM waveform, and a pin-change interrupt source. From the port register bits and the enables of these functions, the block works out three pad controls: output enable, output value and pull-up enable. In two-wire mode it makes the pin an open-drain line.

The block also gates the pad's digital input buffer and passes the pad input through a synchronizer. It compares successive synchronized samples and raises a one-cycle pin-change request when they differ. That request is issued only while interrupts are enabled and no alternate function owns the pin. During sleep, the input buffer stays powered only when it is needed to wake the chip. The pad itself lies outside the block and is seen only as enable and value signals. The shift logic, the timer and the interrupt vectoring also lie outside.

Top module: `mio_pin_ctrl`

## Requirements
- R1: Serial mode is a 2-bit code: 00 = off, 01 = three-wire, 10 = two-wire, 11 = treated as off. In three-wire mode with PWM disabled, the pad follows the normal port rule of R5.
- R2: In two-wire mode (code 10) the pad never drives high. `pad_out` is 0, and `pad_oe` is 1 exactly when `port_dir` is 1 and at least one of `port_data` or `ser_bit` is 0.
- R3: In two-wire mode `pad_pu` is 0 whatever `pull_req`, `port_dir` and `port_data` hold.
- R4: When `pwm_en` is 1 and the serial mode is 00 or 11, `pad_oe` equals `port_dir` and `pad_out` is the inverse of `pwm_wave`. In three-wire mode, `pwm_en` has no effect on the pad.
- R5: In normal port control, `pad_oe` equals `port_dir` and `pad_out` equals `port_data`. In this case, and in the cases of R1 and R4, `pad_pu` is `pull_req AND NOT port_dir AND port_data`.
- R6: The pin is masked when `pwm_en` is 1 or the serial mode is 01 or 10. `pc_irq` is 1 only when `gie` and `pc_en` are both 1 and the pin is not masked.
- R7: `din_en` is 1 when `sleep` is 0. During sleep, `din_en` is 1 only if `gie` and `pc_en` are 1 and the pin is not masked.
- R8: `pin_sync` equals `pad_in AND din_en` delayed by `SYNC_STAGES` clock edges, so it reads 0 while the input buffer is disabled.
- R9: `pc_irq` is 1 for exactly the cycle in which `pin_sync` differs from its value one cycle earlier, qualified as in R6. A single input edge gives a single one-cycle pulse.
- R10: While `rst_n` is low, all synchronizer stages are cleared and `pin_sync` and `pc_irq` are 0. With all inputs at 0, the pin is an undriven input with the pull-up off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_data | input | 1 | Port data register bit |
| port_dir | input | 1 | Port direction bit, 1 = output |
| pull_req | input | 1 | Pull-up allowed by port logic |
| ser_mode | input | 2 | Serial mode code (see R1) |
| ser_bit | input | 1 | Serial shift register output bit |
| pwm_en | input | 1 | Inverted PWM output enable |
| pwm_wave | input | 1 | PWM waveform before inversion |
| gie | input | 1 | Global interrupt enable |
| pc_en | input | 1 | Pin-change interrupt enable |
| sleep | input | 1 | Chip is in sleep |
| pad_in | input | 1 | Raw pad input level |
| pad_oe | output | 1 | Pad output enable |
| pad_out | output | 1 | Pad output value |
| pad_pu | output | 1 | Pad pull-up enable |
| din_en | output | 1 | Digital input buffer enable |
| pin_sync | output | 1 | Synchronized pin value |
| pc_irq | output | 1 | One-cycle pin-change request |

## Verification
The bench builds the block with `SYNC_STAGES` = 2. It sweeps all 2048 combinations of the serial mode code and the nine static control bits, and checks every pad control and the input enable against formulas written out in the bench. It then sends a rising and a falling pad edge through each of the 64 combinations of mode, PWM enable, interrupt enables and sleep. This exercises the synchronizer delay, the input gating to 0 and the single-pulse request for every masking case.

// File: rtl/mio_pkg.sv
package mio_pkg;
  typedef enum logic [1:0] {
    SER_OFF   = 2'b00,
    SER_3WIRE = 2'b01,
    SER_2WIRE = 2'b10,
    SER_RSVD  = 2'b11
  } ser_mode_e;

  typedef struct packed {
    logic oe;
    logic val;
    logic pu;
  } pad_ctl_t;
endpackage

// File: rtl/mio_pad_mux.sv
module mio_pad_mux
  import mio_pkg::*;
(
  input  logic      port_data,
  input  logic      port_dir,
  input  logic      pull_req,
  input  ser_mode_e mode,
  input  logic      ser_bit,
  input  logic      pwm_en,
  input  logic      pwm_wave,
  output pad_ctl_t  ctl
);
  logic two_wire;
  logic three_wire;
  logic pwm_owns;
  logic port_pu;

  assign two_wire   = (mode == SER_2WIRE);
  assign three_wire = (mode == SER_3WIRE);
  assign pwm_owns   = pwm_en && !two_wire && !three_wire;
  assign port_pu    = pull_req && !port_dir && port_data;

  // Precedence: open-drain line, then inverted waveform, then plain port.
  always_comb begin
    ctl = '{oe: port_dir, val: port_data, pu: port_pu};
    if (two_wire) begin
      ctl.oe  = port_dir && !(port_data && ser_bit);
      ctl.val = 1'b0;
      ctl.pu  = 1'b0;
    end else if (pwm_owns) begin
      ctl.val = !pwm_wave;
    end
  end
endmodule

// File: rtl/mio_irq_gate.sv
module mio_irq_gate
  import mio_pkg::*;
(
  input  ser_mode_e mode,
  input  logic      pwm_en,
  input  logic      gie,
  input  logic      pc_en,
  input  logic      sleep,
  output logic      pc_live,
  output logic      din_en
);
  logic masked;

  assign masked  = pwm_en || (mode == SER_3WIRE) || (mode == SER_2WIRE);
  assign pc_live = gie && pc_en && !masked;
  assign din_en  = !sleep || pc_live;
endmodule

// File: rtl/mio_sync_edge.sv
module mio_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_sync,
  output logic changed
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] stage;
  logic          prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= 1'b0;
    else        stage[0] <= d_in;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[g] <= 1'b0;
      else        stage[g] <= stage[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= stage[LAST];
  end

  assign q_sync  = stage[LAST];
  assign changed = stage[LAST] ^ prev_q;
endmodule

// File: rtl/mio_pin_ctrl.sv
module mio_pin_ctrl
  import mio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_data,
  input  logic       port_dir,
  input  logic       pull_req,
  input  logic [1:0] ser_mode,
  input  logic       ser_bit,
  input  logic       pwm_en,
  input  logic       pwm_wave,
  input  logic       gie,
  input  logic       pc_en,
  input  logic       sleep,
  input  logic       pad_in,
  output logic       pad_oe,
  output logic       pad_out,
  output logic       pad_pu,
  output logic       din_en,
  output logic       pin_sync,
  output logic       pc_irq
);
  ser_mode_e mode;
  pad_ctl_t  ctl;
  logic      pc_live;
  logic      changed;

  assign mode = ser_mode_e'(ser_mode);

  mio_pad_mux u_mux (
    .port_data (port_data),
    .port_dir  (port_dir),
    .pull_req  (pull_req),
    .mode      (mode),
    .ser_bit   (ser_bit),
    .pwm_en    (pwm_en),
    .pwm_wave  (pwm_wave),
    .ctl       (ctl)
  );

  mio_irq_gate u_gate (
    .mode    (mode),
    .pwm_en  (pwm_en),
    .gie     (gie),
    .pc_en   (pc_en),
    .sleep   (sleep),
    .pc_live (pc_live),
    .din_en  (din_en)
  );

  mio_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_in    (pad_in && din_en),
    .q_sync  (pin_sync),
    .changed (changed)
  );

  assign pad_oe  = ctl.oe;
  assign pad_out = ctl.val;
  assign pad_pu  = ctl.pu;
  assign pc_irq  = changed && pc_live;
endmodule

// File: rtl/mio_pin_ctrl_chk.sv
module mio_pin_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ser_mode,
  input logic       pwm_en,
  input logic       gie,
  input logic       pc_en,
  input logic       sleep,
  input logic       pad_oe,
  input logic       pad_out,
  input logic       pad_pu,
  input logic       din_en,
  input logic       pin_sync,
  input logic       pc_irq
);
  logic mask_c;
  assign mask_c = pwm_en || ser_mode == 2'b01 || ser_mode == 2'b10;

  p_open_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode == 2'b10 && pad_oe) |-> !pad_out);

  p_no_pullup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode == 2'b10) |-> !pad_pu);

  p_irq_qualified_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_irq |-> (gie && pc_en && !mask_c));

  p_sleep_buffer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !(gie && pc_en && !mask_c)) |-> !din_en);

  p_irq_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_irq |-> (pin_sync != $past(pin_sync)));
endmodule

bind mio_pin_ctrl mio_pin_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ser_mode (ser_mode),
  .pwm_en   (pwm_en),
  .gie      (gie),
  .pc_en    (pc_en),
  .sleep    (sleep),
  .pad_oe   (pad_oe),
  .pad_out  (pad_out),
  .pad_pu   (pad_pu),
  .din_en   (din_en),
  .pin_sync (pin_sync),
  .pc_irq   (pc_irq)
);

// File: tb/mio_pin_ctrl_bench.sv
module mio_pin_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STAGES     = 2;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_data = 0, port_dir = 0, pull_req = 0, ser_bit = 0;
  logic [1:0] ser_mode = 2'b00;
  logic       pwm_en = 0, pwm_wave = 0, gie = 0, pc_en = 0, sleep = 0, pad_in = 0;
  logic       pad_oe, pad_out, pad_pu, din_en, pin_sync, pc_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mio_pin_ctrl #(.SYNC_STAGES(STAGES)) u_mio_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .port_data(port_data), .port_dir(port_dir),
    .pull_req(pull_req), .ser_mode(ser_mode), .ser_bit(ser_bit),
    .pwm_en(pwm_en), .pwm_wave(pwm_wave), .gie(gie), .pc_en(pc_en),
    .sleep(sleep), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu), .din_en(din_en), .pin_sync(pin_sync), .pc_irq(pc_irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b (mode=%0b dir=%0b dat=%0b sb=%0b pwm=%0b wv=%0b pr=%0b gie=%0b pce=%0b slp=%0b)",
               req, act, exp, ser_mode, port_dir, port_data, ser_bit, pwm_en,
               pwm_wave, pull_req, gie, pc_en, sleep);
    end
  endtask

  function automatic logic masked_f(input logic [1:0] m, input logic p);
    return p || m == 2'b01 || m == 2'b10;
  endfunction

  function automatic logic live_f(input logic [1:0] m, input logic p,
                                  input logic g, input logic e);
    return g && e && !masked_f(m, p);
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R10: reset state with all inputs low
    repeat (3) @(negedge clk);
    check("R10 pin_sync in reset", pin_sync, 1'b0);
    check("R10 pc_irq in reset", pc_irq, 1'b0);
    check("R10 pad_oe in reset", pad_oe, 1'b0);
    check("R10 pad_pu in reset", pad_pu, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // Static sweep: every mode code and every static control bit
    for (int v = 0; v < 2048; v++) begin
      logic [1:0] m;
      logic tw, thr, pwm_act, e_oe, e_out, e_pu, e_din;
      m = v[10:9];
      {port_dir, port_data, ser_bit, pwm_en, pwm_wave, pull_req, gie, pc_en, sleep} = v[8:0];
      ser_mode = m;
      #1;
      tw      = (m == 2'b10);
      thr     = (m == 2'b01);
      pwm_act = pwm_en && !tw && !thr;
      if (tw) begin
        e_oe = port_dir && (!port_data || !ser_bit);
        e_out = 1'b0;
        e_pu  = 1'b0;
      end else begin
        e_oe  = port_dir;
        e_out = pwm_act ? !pwm_wave : port_data;
        e_pu  = pull_req && !port_dir && port_data;
      end
      e_din = !sleep || live_f(m, pwm_en, gie, pc_en);
      if (tw) begin
        check("R2 open-drain enable", pad_oe, e_oe);
        check("R2 never drive high", pad_out, e_out);
        check("R3 pull-up forced off", pad_pu, e_pu);
      end else if (pwm_act) begin
        check("R4 pwm enable", pad_oe, e_oe);
        check("R4 inverted wave", pad_out, e_out);
        check("R5 pull-up under pwm", pad_pu, e_pu);
      end else if (thr) begin
        check("R1 three-wire oe", pad_oe, e_oe);
        check("R1 three-wire out", pad_out, e_out);
        check("R1 three-wire pu", pad_pu, e_pu);
      end else begin
        check("R5 port oe", pad_oe, e_oe);
        check("R5 port out", pad_out, e_out);
        check("R5 port pu", pad_pu, e_pu);
      end
      check("R7 input enable", din_en, e_din);
    end

    // Dynamic sweep: edges through every interrupt/sleep/mask case
    for (int v = 0; v < 64; v++) begin
      logic live, den;
      @(negedge clk);
      pad_in = 1'b0;
      {port_dir, port_data, ser_bit, pwm_wave, pull_req} = '0;
      ser_mode = v[5:4];
      {pwm_en, gie, pc_en, sleep} = v[3:0];
      repeat (STAGES + 2) @(negedge clk);
      live = live_f(ser_mode, pwm_en, gie, pc_en);
      den  = !sleep || live;
      check("R9 quiet before edge", pc_irq, 1'b0);
      for (int edge_i = 0; edge_i < 2; edge_i++) begin
        logic lvl;
        lvl = (edge_i == 0);
        pad_in = lvl;
        for (int c = 1; c < STAGES; c++) begin
          @(negedge clk);
          check("R8 not yet through", pin_sync, !lvl && den);
          check("R9 no early pulse", pc_irq, 1'b0);
        end
        @(negedge clk);
        check("R8 sync delay and gating", pin_sync, lvl && den);
        check("R6 qualified pulse", pc_irq, live && den);
        @(negedge clk);
        check("R9 single-cycle pulse", pc_irq, 1'b0);
        check("R8 held value", pin_sync, lvl && den);
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule